// File: doc/BRIEF.md
# Fail-First Vector Zero Search and Loop Branch

This block carries out one step of a vectorised copy loop that stops at a terminator. It receives a small vector of elements, a per-element predicate mask and a loop counter. From these it works out how many elements the step may handle. The active length is the counter, capped at a maximum vector length. The block compares every predicated active element against zero, in lane order.

The first element that equals zero cuts the vector short. In exclusive mode the result length stops just before that element. In inclusive mode the result length keeps the zero element, so a later store also writes the terminator. After the cut, the block subtracts the resulting length from the counter. It raises the loop branch only when no zero was found and work remains.

A flag reports that a zero was found, so the caller can start a zero-fill phase. Elements are 8 or 16 bits wide, chosen per request. The control behaviour is the same for both widths. All results come out of registers.

Top module: `ffvec_cmp_branch`

## Requirements
- R1: The active length is min(ctr_in, MAXVL). When no tested element is zero, vl_out equals this active length.
- R2: A lane whose pred bit is 0 is skipped. It is not tested, its cc_vec bit is 0, and a zero value in it does not shorten the vector.
- R3: cc_vec bit i is 1 exactly when lane i is active, predicated, lies before any failing lane, and is nonzero. Lanes at or beyond the active length read 0.
- R4: Exclusive mode (incl=0): when the first tested lane equal to zero is lane i, vl_out is i and found_fail is 1. Later lanes are not tested.
- R5: Inclusive mode (incl=1): when the first tested lane equal to zero is lane i, vl_out is i+1 and found_fail is 1.
- R6: ctr_out equals ctr_in minus vl_out, where vl_out is the length after the cut and not MAXVL.
- R7: taken is 1 only when found_fail is 0 and ctr_out is nonzero.
- R8: wide=0 tests only bits [7:0] of each 16-bit lane, so the upper byte has no effect. wide=1 tests all 16 bits. Lane i occupies elems[16*i+15:16*i].
- R9: When ctr_in is 0, the block returns vl_out 0, cc_vec 0, ctr_out 0, found_fail 0 and taken 0.
- R10: valid is a single-cycle pulse in the cycle after start is accepted. A start that arrives while valid is 1 is ignored, and the outputs keep their values.
- R11: After reset, valid, vl_out, cc_vec, ctr_out, found_fail and taken are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a step |
| wide | input | 1 | 0: 8-bit elements, 1: 16-bit elements |
| incl | input | 1 | 1: keep the zero element inside the length |
| elems | input | 16*MAXVL | Element lanes, lane i at bits 16*i+15:16*i |
| pred | input | MAXVL | Predicate mask, one bit per lane |
| ctr_in | input | CW | Loop counter before the step |
| valid | output | 1 | Results valid (one-cycle pulse) |
| vl_out | output | clog2(MAXVL+1) | Length after the cut |
| cc_vec | output | MAXVL | Per-lane pass flags |
| ctr_out | output | CW | Counter after the decrement |
| found_fail | output | 1 | A zero element was found |
| taken | output | 1 | Loop branch taken |

## Verification
Some properties are checked on every cycle:
- valid pulses exactly once per accepted start.
- The decremented counter matches the captured input counter minus the reported length.
- The length never exceeds MAXVL.
- No pass flag is set at or above the reported length.
- A taken branch never coincides with a found zero or an exhausted counter.

Other behaviours are shown only by the bench's scenarios:
- The exact cut position in each mode.
- Skipped lanes that hold zero.
- The upper byte being ignored in 8-bit mode.
- The zero-counter case.
- The outputs holding when a start arrives while busy.

// File: rtl/ffvec_cmp_branch.sv
module ffvec_cmp_branch #(
  parameter int MAXVL = 4,
  parameter int CW    = 16,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  wide,
  input  logic                  incl,
  input  logic [16*MAXVL-1:0]   elems,
  input  logic [MAXVL-1:0]      pred,
  input  logic [CW-1:0]         ctr_in,
  output logic                  valid,
  output logic [VLW-1:0]        vl_out,
  output logic [MAXVL-1:0]      cc_vec,
  output logic [CW-1:0]         ctr_out,
  output logic                  found_fail,
  output logic                  taken
);

  logic [MAXVL-1:0] lane_zero;
  logic [CW-1:0]    avl;
  logic [VLW-1:0]   vl_n;
  logic [MAXVL-1:0] cc_n;
  logic             fail_n;
  logic [CW-1:0]    ctr_n;
  logic             accept;

  for (genvar g = 0; g < MAXVL; g++) begin : g_lane
    assign lane_zero[g] = wide ? (elems[16*g +: 16] == 16'd0)
                               : (elems[16*g +: 8]  == 8'd0);
  end

  assign avl    = (ctr_in > CW'(MAXVL)) ? CW'(MAXVL) : ctr_in;
  assign accept = start && !valid;

  always_comb begin
    logic stop;
    stop   = 1'b0;
    fail_n = 1'b0;
    cc_n   = '0;
    vl_n   = VLW'(avl);
    for (int i = 0; i < MAXVL; i++) begin
      if (!stop && (CW'(i) < avl) && pred[i]) begin
        if (lane_zero[i]) begin
          stop   = 1'b1;
          fail_n = 1'b1;
          vl_n   = incl ? VLW'(i + 1) : VLW'(i);
        end else begin
          cc_n[i] = 1'b1;
        end
      end
    end
  end

  assign ctr_n = ctr_in - CW'(vl_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      vl_out     <= '0;
      cc_vec     <= '0;
      ctr_out    <= '0;
      found_fail <= 1'b0;
      taken      <= 1'b0;
    end else begin
      valid <= accept;
      if (accept) begin
        vl_out     <= vl_n;
        cc_vec     <= cc_n;
        ctr_out    <= ctr_n;
        found_fail <= fail_n;
        taken      <= !fail_n && (ctr_n != '0);
      end
    end
  end

endmodule

// File: rtl/ffvec_cmp_branch_chk.sv
module ffvec_cmp_branch_chk #(
  parameter int MAXVL = 4,
  parameter int CW    = 16,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CW-1:0]    ctr_in,
  input logic             valid,
  input logic [VLW-1:0]   vl_out,
  input logic [MAXVL-1:0] cc_vec,
  input logic [CW-1:0]    ctr_out,
  input logic             found_fail,
  input logic             taken
);

  assert_valid_follows_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid) |=> valid);

  assert_valid_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !valid) |=> !valid);

  assert_ctr_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid) |=> (ctr_out == $past(ctr_in) - CW'(vl_out)));

  assert_len_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (vl_out <= VLW'(MAXVL)));

  assert_pass_inside_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((cc_vec >> vl_out) == '0));

  assert_taken_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && taken) |-> (!found_fail && ctr_out != '0));

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !valid) |=> ($stable(vl_out) && $stable(ctr_out) && $stable(cc_vec)));

endmodule

bind ffvec_cmp_branch ffvec_cmp_branch_chk #(.MAXVL(MAXVL), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ctr_in(ctr_in), .valid(valid),
  .vl_out(vl_out), .cc_vec(cc_vec), .ctr_out(ctr_out),
  .found_fail(found_fail), .taken(taken)
);

// File: tb/test_ffvec_cmp_branch.sv
module test_ffvec_cmp_branch;
  localparam int MAXVL = 4;
  localparam int CW    = 16;
  localparam int VLW   = $clog2(MAXVL + 1);

  logic clk = 0, rst_n = 0, start = 0, wide = 0, incl = 0;
  logic [16*MAXVL-1:0] elems = '0;
  logic [MAXVL-1:0] pred = '0;
  logic [CW-1:0] ctr_in = '0;
  logic valid, found_fail, taken;
  logic [VLW-1:0] vl_out;
  logic [MAXVL-1:0] cc_vec;
  logic [CW-1:0] ctr_out;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ffvec_cmp_branch #(.MAXVL(MAXVL), .CW(CW)) i_ffvec_cmp_branch (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .incl(incl),
    .elems(elems), .pred(pred), .ctr_in(ctr_in), .valid(valid),
    .vl_out(vl_out), .cc_vec(cc_vec), .ctr_out(ctr_out),
    .found_fail(found_fail), .taken(taken));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(string req, logic [63:0] e, logic [3:0] p, int c, logic w, logic inc,
                      int evl, int ecc, int ectr, int efail, int etk);
    @(negedge clk);
    elems = e; pred = p; ctr_in = CW'(c); wide = w; incl = inc; start = 1;
    @(negedge clk);
    start = 0;
    chk({req, " valid"}, int'(valid), 1);
    chk({req, " vl"}, int'(vl_out), evl);
    chk({req, " cc"}, int'(cc_vec), ecc);
    chk({req, " ctr"}, int'(ctr_out), ectr);
    chk({req, " fail"}, int'(found_fail), efail);
    chk({req, " taken"}, int'(taken), etk);
    @(negedge clk);
    chk({req, " valid drop"}, int'(valid), 0);
  endtask

  task automatic t_reset;
    chk("R11 valid", int'(valid), 0);
    chk("R11 vl", int'(vl_out), 0);
    chk("R11 cc", int'(cc_vec), 0);
    chk("R11 ctr", int'(ctr_out), 0);
    chk("R11 fail", int'(found_fail), 0);
    chk("R11 taken", int'(taken), 0);
  endtask

  task automatic t_len;
    step("R1 cap", 64'h0004_0003_0002_0001, 4'hF, 10, 0, 0, 4, 'hF, 6, 0, 1);
    step("R1 short", 64'h0004_0003_0002_0001, 4'hF, 3, 0, 0, 3, 'h7, 0, 0, 0);
    step("R3 beyond", 64'h0000_0003_0002_0001, 4'hF, 2, 0, 0, 2, 'h3, 0, 0, 0);
  endtask

  task automatic t_fail;
    step("R4 excl", 64'h0000_0007_0000_0005, 4'hF, 9, 0, 0, 1, 'h1, 8, 1, 0);
    step("R5 incl", 64'h0000_0007_0000_0005, 4'hF, 9, 0, 1, 2, 'h1, 7, 1, 0);
    step("R5 lane0", 64'h0001_0001_0001_0000, 4'hF, 9, 0, 1, 1, 'h0, 8, 1, 0);
    step("R6 R7 dec", 64'h0000_0007_0000_0005, 4'hF, 9, 0, 0, 1, 'h1, 8, 1, 0);
  endtask

  task automatic t_pred;
    step("R2 skip", 64'h0000_0007_0000_0005, 4'b1101, 9, 0, 0, 3, 'h5, 6, 1, 0);
  endtask

  task automatic t_width;
    step("R8 byte", 64'h0011_0011_0011_0100, 4'hF, 4, 0, 0, 0, 'h0, 4, 1, 0);
    step("R8 half", 64'h0011_0011_0011_0100, 4'hF, 5, 1, 0, 4, 'hF, 1, 0, 1);
  endtask

  task automatic t_zero;
    step("R9 ctr0", 64'h0000_0000_0000_0000, 4'hF, 0, 0, 0, 0, 'h0, 0, 0, 0);
  endtask

  task automatic t_busy;
    @(negedge clk);
    elems = 64'h0004_0003_0002_0001; pred = 4'hF; ctr_in = 16'd10; wide = 0; incl = 0; start = 1;
    @(negedge clk);
    chk("R10 first valid", int'(valid), 1);
    chk("R10 first vl", int'(vl_out), 4);
    elems = 64'h0000_0000_0000_0000; ctr_in = 16'd2;
    @(negedge clk);
    start = 0;
    chk("R10 ignored valid", int'(valid), 0);
    chk("R10 ignored vl", int'(vl_out), 4);
    chk("R10 ignored ctr", int'(ctr_out), 6);
    chk("R10 ignored fail", int'(found_fail), 0);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_len();
    t_fail();
    t_pred();
    t_width();
    t_zero();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule